// File: doc/BRIEF.md
# MFM Address-Mark Synchronizer and Byte Decoder

This block sits after a data separator. It receives a serial MFM code-bit stream with a one-cycle enable for each code bit. An MFM stream carries a clock bit and a data bit in every pair of code bits, and the stream does not show which of the two positions holds data. The block resolves this by searching for a special sync word. This word is a data byte whose encoding is missing one clock transition, so the regular preamble and ordinary encoded data cannot produce it. When the word completes, its last code bit is known to sit in a data position. From that point the internal divide-by-two data strobe is forced into step with the data positions.

A frame is accepted only after a set number of sync words arrive back to back, each 16 code bits after the previous one. The block then keeps only the data position of each code-bit pair. It packs these bits into bytes, most significant bit first. A fixed count of payload bytes is followed by a fixed count of check bytes, and the check bytes are flagged but not verified. After the last check byte, the block pulses a completion flag and goes back to searching. The divide-by-two strobe is brought out so that a downstream data register can be clocked at the data rate.

Top module: `mfm_sync_decoder`

## Requirements
- R1: After a synchronous active-low reset, and after any later reset, `byte_valid`, `byte_is_crc`, `sync_found` and `frame_done` are low, and the block is searching for a sync word.
- R2: On every code bit that completes the 16-bit sync word 16'h4489 while the block is unlocked, the data strobe is realigned. The next code bit is treated as a clock position and the one after it as a data position. While locked, `data_en` is high on every second `code_en`, starting with the second `code_en` after lock, and is never high without `code_en`.
- R3: Lock requires MARKS sync words, each completed exactly 16 code bits after the previous one. If a code bit arrives 16 code bits after a sync word and does not complete another one, the block returns to searching and emits no bytes.
- R4: While locked, the data-position bits are shifted into a byte most significant bit first. Each completed byte appears on `byte_data`, and `byte_valid` is high for exactly one cycle.
- R5: Each frame delivers DATA_BYTES payload bytes with `byte_is_crc` low, then CRC_BYTES check bytes with `byte_is_crc` high. `byte_is_crc` is high only together with `byte_valid`.
- R6: `frame_done` is high for exactly one cycle, in the cycle after the `byte_valid` of the last check byte. In that cycle `sync_found` is already low.
- R7: `sync_found` rises in the cycle after the last sync word completes and stays high until the frame ends. `byte_valid` is never high while `sync_found` is low.
- R8: A preamble made only of encoded zero bytes (code pattern 1010...), and gap filler, never cause lock.
- R9: Recovery does not depend on the starting code-bit phase. One or two extra code bits before the preamble give the same recovered bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| code_en | input | 1 | One-cycle qualifier for each incoming code bit |
| code_bit | input | 1 | Recovered MFM code bit, valid with `code_en` |
| byte_data | output | 8 | Last assembled byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| byte_is_crc | output | 1 | Marks a strobed byte as a trailing check byte |
| sync_found | output | 1 | High from lock until the end of the frame |
| frame_done | output | 1 | One-cycle pulse after the last check byte |
| data_en | output | 1 | Divide-by-two data-rate strobe, a subset of `code_en` |

## Verification
The properties assume that `code_en` is never high in two cycles in a row. This makes two data positions at least two cycles apart, which single-cycle byte strobes depend on. The properties also assume that the stream is valid MFM, so that the sync word cannot appear inside locked data. The bench spaces every code bit three clock cycles apart. It produces all data with a true MFM encoder that inserts the inverted clock bit where the coding rule requires it, and it writes the sync word only as raw code bits. Random payloads, fixed patterns, phase slips, a truncated sync run and a reset during a frame are all drawn from that legal stream.

// File: rtl/mfm_sync_pkg.sv
// Shared definitions for the MFM synchronizer.
// Assumes a 16-code-bit sync word and byte-wide data.
package mfm_sync_pkg;
    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SYNCED = 2'd1,
        ST_DATA   = 2'd2,
        ST_CRC    = 2'd3
    } sync_state_t;

    localparam int unsigned SYNC_WORD_W = 16;
    localparam logic [SYNC_WORD_W-1:0] SYNC_WORD_DEFAULT = 16'h4489;
endpackage

// File: rtl/mfm_mark_detect.sv
// Sliding-window sync-word detector.
// Keeps the last WORD_W code bits in a shift register. Flags (combinationally)
// the code_en cycle whose incoming bit completes the sync word.
// Assumes code_bit is only meaningful while code_en is high.
module mfm_mark_detect #(
    parameter int unsigned WORD_W = 16,
    parameter logic [WORD_W-1:0] WORD = 16'h4489
) (
    input  logic clk,
    input  logic rst_n,
    input  logic code_en,
    input  logic code_bit,
    output logic mark_now
);
    logic [WORD_W-1:0] window_q;
    logic [WORD_W-1:0] window_next;

    // Candidate window including the bit arriving this cycle.
    always_comb window_next = {window_q[WORD_W-2:0], code_bit};

    // Shift one code bit in per code_en.
    always_ff @(posedge clk) begin
        if (!rst_n)
            window_q <= '0;
        else if (code_en)
            window_q <= window_next;
    end

    // A match is only reported on a real code-bit cycle.
    always_comb mark_now = code_en && (window_next == WORD);
endmodule

// File: rtl/mfm_phase_gen.sv
// Divide-by-two data strobe generator.
// Toggles a phase flag on each code bit. A realign request forces the following
// code bit to a clock position, because the bit completing the sync word is data.
module mfm_phase_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic code_en,
    input  logic realign,
    output logic data_en
);
    logic data_phase_q;

    // Track whether the next code bit is in a data position.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_phase_q <= 1'b0;
        else if (code_en)
            data_phase_q <= realign ? 1'b0 : ~data_phase_q;
    end

    // Strobe only on the data-position code bits.
    always_comb data_en = code_en && data_phase_q;
endmodule

// File: rtl/mfm_byte_asm.sv
// Serial-to-parallel byte assembler, most significant bit first.
// Shifts one bit per bit_en while enable is high, and emits a registered
// one-cycle strobe with each full byte. Dropping enable clears the bit count.
module mfm_byte_asm #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_stb
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] shift_next;
    logic [CNT_W-1:0]  bit_cnt_q;

    // Shift register contents after the current bit.
    always_comb shift_next = {shift_q[BYTE_W-2:0], bit_in};

    // Collect bits, and publish a byte when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_cnt_q <= '0;
            byte_out  <= '0;
            byte_stb  <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (!enable) begin
                bit_cnt_q <= '0;
            end else if (bit_en) begin
                shift_q <= shift_next;
                if (bit_cnt_q == LAST_BIT) begin
                    bit_cnt_q <= '0;
                    byte_out  <= shift_next;
                    byte_stb  <= 1'b1;
                end else begin
                    bit_cnt_q <= bit_cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mfm_frame_fsm.sv
// Frame sequencer: HUNT -> SYNCED -> DATA -> CRC -> HUNT.
// Counts consecutive sync words spaced WORD_W code bits apart, then counts
// payload and check bytes from the assembler strobe. Pulses frame_done after
// the last check byte. Assumes valid MFM, so sync words do not occur in data.
module mfm_frame_fsm
    import mfm_sync_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 512,
    parameter int unsigned CRC_BYTES  = 2,
    parameter int unsigned MARKS      = 3,
    parameter int unsigned WORD_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        code_en,
    input  logic        mark_now,
    input  logic        byte_stb,
    output sync_state_t state,
    output logic        frame_done
);
    localparam int unsigned MAX_BYTES = (DATA_BYTES > CRC_BYTES) ? DATA_BYTES : CRC_BYTES;
    localparam int unsigned BC_W = $clog2(MAX_BYTES + 1);
    localparam int unsigned MC_W = $clog2(MARKS + 1);
    localparam int unsigned GAP_W = $clog2(WORD_W);
    localparam logic [BC_W-1:0]  LAST_DATA = BC_W'(DATA_BYTES - 1);
    localparam logic [BC_W-1:0]  LAST_CRC  = BC_W'(CRC_BYTES - 1);
    localparam logic [MC_W-1:0]  LAST_MARK = MC_W'(MARKS - 1);
    localparam logic [GAP_W-1:0] LAST_GAP  = GAP_W'(WORD_W - 1);

    logic [BC_W-1:0]  byte_cnt_q;
    logic [MC_W-1:0]  mark_cnt_q;
    logic [GAP_W-1:0] gap_cnt_q;

    // State transitions and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            byte_cnt_q <= '0;
            mark_cnt_q <= '0;
            gap_cnt_q  <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (mark_now) begin
                        mark_cnt_q <= MC_W'(1);
                        gap_cnt_q  <= '0;
                        byte_cnt_q <= '0;
                        state      <= (MARKS == 1) ? ST_DATA : ST_SYNCED;
                    end
                end
                ST_SYNCED: begin
                    if (code_en) begin
                        if (mark_now) begin
                            gap_cnt_q <= '0;
                            if (mark_cnt_q == LAST_MARK) begin
                                byte_cnt_q <= '0;
                                state      <= ST_DATA;
                            end else begin
                                mark_cnt_q <= mark_cnt_q + 1'b1;
                            end
                        end else if (gap_cnt_q == LAST_GAP) begin
                            state <= ST_HUNT;
                        end else begin
                            gap_cnt_q <= gap_cnt_q + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (byte_stb) begin
                        if (byte_cnt_q == LAST_DATA) begin
                            byte_cnt_q <= '0;
                            state      <= ST_CRC;
                        end else begin
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    if (byte_stb) begin
                        if (byte_cnt_q == LAST_CRC) begin
                            byte_cnt_q <= '0;
                            frame_done <= 1'b1;
                            state      <= ST_HUNT;
                        end else begin
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/mfm_sync_decoder.sv
// Top level: MFM sync-word search, data-phase alignment and byte recovery.
// Input is a recovered code-bit stream with a one-cycle code_en per bit.
// Assumes code_en is never high two cycles running. Check bytes are flagged,
// not verified.
module mfm_sync_decoder
    import mfm_sync_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 512,
    parameter int unsigned CRC_BYTES  = 2,
    parameter int unsigned MARKS      = 3,
    parameter logic [SYNC_WORD_W-1:0] SYNC_WORD = SYNC_WORD_DEFAULT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       code_en,
    input  logic       code_bit,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       byte_is_crc,
    output logic       sync_found,
    output logic       frame_done,
    output logic       data_en
);
    sync_state_t state;
    logic        mark_now;
    logic        locked;
    logic        realign;
    logic        asm_stb;

    // Locked means the data phase is fixed for the rest of the frame.
    always_comb begin
        locked  = (state == ST_DATA) || (state == ST_CRC);
        realign = mark_now && !locked;
    end

    mfm_mark_detect #(
        .WORD_W (SYNC_WORD_W),
        .WORD   (SYNC_WORD)
    ) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_en  (code_en),
        .code_bit (code_bit),
        .mark_now (mark_now)
    );

    mfm_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_en (code_en),
        .realign (realign),
        .data_en (data_en)
    );

    mfm_byte_asm #(
        .BYTE_W (8)
    ) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (locked),
        .bit_en   (data_en),
        .bit_in   (code_bit),
        .byte_out (byte_data),
        .byte_stb (asm_stb)
    );

    mfm_frame_fsm #(
        .DATA_BYTES (DATA_BYTES),
        .CRC_BYTES  (CRC_BYTES),
        .MARKS      (MARKS),
        .WORD_W     (SYNC_WORD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_en    (code_en),
        .mark_now   (mark_now),
        .byte_stb   (asm_stb),
        .state      (state),
        .frame_done (frame_done)
    );

    // Output qualifiers.
    always_comb begin
        byte_valid  = asm_stb;
        byte_is_crc = asm_stb && (state == ST_CRC);
        sync_found  = locked;
    end
endmodule

// File: rtl/mfm_sync_decoder_chk.sv
// Property checker for mfm_sync_decoder, attached with bind.
// Assumes code_en is never high on consecutive cycles.
module mfm_sync_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic code_en,
    input logic byte_valid,
    input logic byte_is_crc,
    input logic sync_found,
    input logic frame_done,
    input logic data_en
);
    logic expect_data_q;

    // Expected data-position parity since lock: first code bit is a clock bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_found)
            expect_data_q <= 1'b0;
        else if (code_en)
            expect_data_q <= ~expect_data_q;
    end

    AST_STROBE_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> code_en); // R2
    AST_LOCKED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (code_en && sync_found) |-> (data_en == expect_data_q)); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R4
    AST_CRC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_is_crc |-> byte_valid); // R5
    AST_DONE_AFTER_CRC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!sync_found && $past(byte_is_crc))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R6
    AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> sync_found); // R7
endmodule

bind mfm_sync_decoder mfm_sync_decoder_chk u_chk (.*);

// File: tb/tb_mfm_sync_decoder.sv
`timescale 1ns/1ps
module tb_mfm_sync_decoder;
    localparam int unsigned NDATA = 24;
    localparam int unsigned NCRC  = 2;
    localparam int unsigned NMARK = 3;
    localparam logic [15:0] SYNC  = 16'h4489;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       code_en = 1'b0;
    logic       code_bit = 1'b0;
    logic [7:0] byte_data;
    logic       byte_valid, byte_is_crc, sync_found, frame_done, data_en;

    int checks = 0;
    int fails = 0;
    logic prev_code = 1'b0;

    logic [7:0] got [0:63];
    logic       got_crc [0:63];
    int         got_n = 0;
    int         done_n = 0;
    int         done_at = -1;
    logic [7:0] exp_b [0:63];

    always #5 clk = ~clk;

    mfm_sync_decoder #(.DATA_BYTES(NDATA), .CRC_BYTES(NCRC), .MARKS(NMARK)) dut (
        .clk(clk), .rst_n(rst_n), .code_en(code_en), .code_bit(code_bit),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_is_crc(byte_is_crc),
        .sync_found(sync_found), .frame_done(frame_done), .data_en(data_en)
    );

    // Capture output bytes and completion pulses away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid && got_n < 64) begin
                got[got_n] = byte_data;
                got_crc[got_n] = byte_is_crc;
                got_n++;
            end
            if (frame_done) begin
                done_n++;
                done_at = got_n;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_code(input logic b);
        @(negedge clk);
        code_bit = b;
        code_en = 1'b1;
        @(negedge clk);
        code_en = 1'b0;
        @(negedge clk);
        prev_code = b;
    endtask

    // MFM encoder: data 1 -> 01, data 0 -> (inverse of previous code bit) 0.
    task automatic put_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            if (d[i]) begin
                put_code(1'b0);
                put_code(1'b1);
            end else begin
                put_code(~prev_code);
                put_code(1'b0);
            end
        end
    endtask

    task automatic put_sync();
        for (int i = 15; i >= 0; i--) put_code(SYNC[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // kind: 0 random, 1 all zero, 2 all ones, 3 sync-byte value.
    task automatic run_frame(input int slip, input int kind, input string req);
        int d0;
        d0 = done_n;
        got_n = 0;
        done_at = -1;
        for (int i = 0; i < NDATA + NCRC; i++) begin
            case (kind)
                1: exp_b[i] = 8'h00;
                2: exp_b[i] = 8'hFF;
                3: exp_b[i] = 8'hA1;
                default: exp_b[i] = 8'($urandom_range(0, 255));
            endcase
        end
        for (int s = 0; s < slip; s++) put_code(1'($urandom_range(0, 1)));
        for (int i = 0; i < 12; i++) put_byte(8'h00);
        for (int m = 0; m < NMARK; m++) put_sync();
        for (int i = 0; i < NDATA + NCRC; i++) begin
            put_byte(exp_b[i]);
            if (i == NDATA / 2) chk("R7 sync_found mid-frame", int'(sync_found), 1);
        end
        for (int i = 0; i < 3; i++) put_byte(8'h4E);
        chk({req, " R4 byte count"}, got_n, NDATA + NCRC);
        for (int i = 0; i < NDATA + NCRC; i++) begin
            chk((i == 0) ? "R2 first byte" : "R4 byte value", int'(got[i]), int'(exp_b[i]));
            chk("R5 check flag", int'(got_crc[i]), (i >= NDATA) ? 1 : 0);
        end
        chk("R6 one completion pulse", done_n - d0, 1);
        chk("R6 pulse after last byte", done_at, NDATA + NCRC);
        chk("R6 unlocked after frame", int'(sync_found), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1: quiet outputs after reset
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 sync_found", int'(sync_found), 0);
        chk("R1 frame_done", int'(frame_done), 0);
        chk("R1 byte_is_crc", int'(byte_is_crc), 0);

        // R8: preamble and filler alone never lock
        got_n = 0;
        for (int i = 0; i < 20; i++) put_byte(8'h00);
        for (int i = 0; i < 6; i++) put_byte(8'h4E);
        chk("R8 no bytes", got_n, 0);
        chk("R8 no lock", int'(sync_found), 0);

        // R3: truncated sync run falls back to search
        for (int run = 1; run < NMARK; run++) begin
            int d0;
            d0 = done_n;
            got_n = 0;
            for (int i = 0; i < 8; i++) put_byte(8'h00);
            for (int m = 0; m < run; m++) put_sync();
            for (int i = 0; i < NDATA + NCRC + 4; i++) put_byte(8'h00);
            chk("R3 no bytes", got_n, 0);
            chk("R3 no lock", int'(sync_found), 0);
            chk("R3 no completion", done_n - d0, 0);
        end

        // Main frames, with R9 code-bit slips
        run_frame(0, 0, "R9 slip0");
        run_frame(1, 0, "R9 slip1");
        run_frame(2, 0, "R9 slip2");
        run_frame(1, 1, "R4 zeros");
        run_frame(2, 2, "R4 ones");
        run_frame(0, 3, "R4 syncval");

        // R1: reset mid-frame, then a clean frame
        for (int i = 0; i < 10; i++) put_byte(8'h00);
        for (int m = 0; m < NMARK; m++) put_sync();
        for (int i = 0; i < 5; i++) put_byte(8'h5A);
        chk("R1 locked before reset", int'(sync_found), 1);
        do_reset();
        chk("R1 sync_found after reset", int'(sync_found), 0);
        chk("R1 byte_valid after reset", int'(byte_valid), 0);
        prev_code = 1'b0;
        run_frame(1, 0, "R1 recover");
        for (int f = 0; f < 2; f++) run_frame(f + 1, 0, "R9 random");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1500000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule